// File: doc/BRIEF.md
# Tensor Tile Address Generator

This block walks one rectangular tile of a tensor of up to five dimensions that sits in global memory. For each element position in the tile it issues a single request on a valid/ready stream. Each request carries the byte address of the element, its per-dimension coordinates, a flag for positions that fall outside the tensor, and the value the destination should receive in place of a read at such a position. A copy engine places the block in front of its memory port. The engine drops the out-of-range requests onto a fill path, so the tensor in memory is neither read nor written for those positions.

A start pulse captures a descriptor and the tile origin. The descriptor holds the base address, the rank, the element size code, the fill policy, and per-dimension extents, byte strides, element steps and box sizes. Extents, box sizes and steps count elements. Strides for dimensions 1 and up count bytes. Dimension 0 is contiguous, so its byte offset is its coordinate shifted left by the element size code. The walk then runs on its own until the last request is accepted, and a one-cycle done pulse follows.

Top module: `tile_addr_gen`

## Requirements
- R1: A start pulse is taken only while no walk is in progress. It captures the origin and all descriptor inputs. Changes on those inputs after capture, and start pulses during a walk, do not alter the requests of the current walk and do not add any.
- R2: Dimension 0 varies fastest and dimension rank-1 slowest. Within dimension d the offset takes the values 0, step[d], 2*step[d] and so on while it stays below box[d]. Dimensions at or above the rank contribute one position, so the walk has exactly the product of ceil(box[d]/step[d]) over the active dimensions as its request count.
- R3: For a dimension below the rank, req_coord[d] is origin[d] + offset[d] as a signed 17-bit value. The origin is a signed 16-bit input. For dimensions at or above the rank, req_coord[d] is 0.
- R4: For an in-bounds request, req_addr = base_addr + (coord[0] << elem_log2) + the sum of coord[d]*stride[d] over 1 <= d < rank, modulo 2^48. The elem_log2 codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 byte elements.
- R5: req_oob is 1 exactly when some dimension below the rank has a coordinate below 0 or at or above extent[d]. Dimensions at or above the rank never raise it.
- R6: An out-of-bounds request has req_addr = 0. Its req_fill is 0 when nan_fill = 0. With nan_fill = 1, req_fill is the quiet NaN zero-extended to 64 bits: 0x7F for 1-byte, 0x7E00 for 2-byte, 0x7FC00000 for 4-byte and 0x7FF8000000000000 for 8-byte elements. An in-bounds request always has req_fill = 0.
- R7: After reset, req_valid and done are 0.
- R8: While req_valid is 1 and req_ready is 0, the request (address, coordinates, flag, fill) holds unchanged on the next cycle.
- R9: done is 1 for exactly the one cycle after the edge that accepts the last request, and req_valid is 0 in that cycle. The block then accepts a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken when idle) |
| origin | input | 5x16 | Signed tile origin per dimension |
| base_addr | input | 48 | Byte address of element (0,...,0) |
| rank | input | 3 | Number of active dimensions, 1 to 5 |
| elem_log2 | input | 2 | log2 of element size in bytes |
| nan_fill | input | 1 | 1 selects NaN fill, 0 selects zero fill |
| extent | input | 5x16 | Tensor size per dimension, in elements |
| stride | input | 4x32 | Byte stride for dimensions 1 to 4 |
| step | input | 5x8 | Element step per dimension |
| box | input | 5x8 | Tile size per dimension, in elements |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Consumer accepts the request |
| req_addr | output | 48 | Byte address, 0 when out of bounds |
| req_coord | output | 5x17 | Signed element coordinates |
| req_oob | output | 1 | Position lies outside the tensor |
| req_fill | output | 64 | Substitute value for out-of-bounds positions |
| done | output | 1 | One-cycle pulse after the final acceptance |

## Verification
The assertions rely on the captured descriptor being well formed. The rank lies between 1 and 5, and every step and box size is at least 1. Under those conditions each accepted request moves at least one coordinate, and an in-bounds dimension 0 coordinate lies inside its extent. Every directed scenario in the bench programs descriptors inside those limits. That holds even where the inputs are deliberately scrambled in the middle of a walk, and the rank chosen there stays in range.

// File: rtl/tile_gen_pkg.sv
package tile_gen_pkg;

    localparam int TG_DIMS   = 5;
    localparam int TG_RANK_W = 3;
    localparam int TG_ORG_W  = 16;
    localparam int TG_CRD_W  = TG_ORG_W + 1;
    localparam int TG_EXT_W  = 16;
    localparam int TG_BOX_W  = 8;
    localparam int TG_STR_W  = 32;
    localparam int TG_ADDR_W = 48;
    localparam int TG_FILL_W = 64;

    typedef enum logic {
        TG_IDLE = 1'b0,
        TG_WALK = 1'b1
    } tg_state_e;

    // captured job: everything the walk needs, frozen at start
    typedef struct packed {
        logic [TG_ADDR_W-1:0]                base;
        logic [TG_RANK_W-1:0]                rank;
        logic [1:0]                          esz_log2;
        logic                                nan_fill;
        logic [TG_DIMS-1:0][TG_ORG_W-1:0]    origin;
        logic [TG_DIMS-1:0][TG_EXT_W-1:0]    extent;
        logic [TG_DIMS-1:1][TG_STR_W-1:0]    stride;
        logic [TG_DIMS-1:0][TG_BOX_W-1:0]    step;
        logic [TG_DIMS-1:0][TG_BOX_W-1:0]    box;
    } tg_job_t;

    // quiet NaN pattern for the element width, zero-extended
    function automatic logic [TG_FILL_W-1:0] tg_nan(input logic [1:0] esz);
        logic [TG_FILL_W-1:0] v;
        case (esz)
            2'd0:    v = TG_FILL_W'(8'h7F);
            2'd1:    v = TG_FILL_W'(16'h7E00);
            2'd2:    v = TG_FILL_W'(32'h7FC0_0000);
            default: v = 64'h7FF8_0000_0000_0000;
        endcase
        return v;
    endfunction

    // sign-extend a coordinate to address width
    function automatic logic [TG_ADDR_W-1:0] tg_sext(input logic [TG_CRD_W-1:0] c);
        return {{(TG_ADDR_W-TG_CRD_W){c[TG_CRD_W-1]}}, c};
    endfunction

endpackage

// File: rtl/tg_dim_stepper.sv
module tg_dim_stepper
    import tile_gen_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                advance,
    input  logic                carry_in,
    input  logic                active,
    input  logic [TG_BOX_W-1:0] step,
    input  logic [TG_BOX_W-1:0] box,
    output logic [TG_BOX_W-1:0] off,
    output logic                last
);
    logic [TG_BOX_W:0] nxt;

    assign nxt  = {1'b0, off} + {1'b0, step};
    // an inactive dimension always sits on its only position
    assign last = !active || (nxt >= {1'b0, box});

    always_ff @(posedge clk) begin
        if (rst) begin
            off <= '0;
        end else if (load) begin
            off <= '0;
        end else if (advance && carry_in) begin
            off <= last ? '0 : nxt[TG_BOX_W-1:0];
        end
    end
endmodule

// File: rtl/tg_bounds.sv
module tg_bounds
    import tile_gen_pkg::*;
(
    input  logic [TG_DIMS-1:0]                dim_on,
    input  logic [TG_DIMS-1:0][TG_ORG_W-1:0]  origin,
    input  logic [TG_DIMS-1:0][TG_EXT_W-1:0]  extent,
    input  logic [TG_DIMS-1:0][TG_BOX_W-1:0]  offs,
    output logic [TG_DIMS-1:0][TG_CRD_W-1:0]  coord,
    output logic                              oob
);
    logic [TG_DIMS-1:0] hit;

    for (genvar d = 0; d < TG_DIMS; d++) begin : g_dim
        logic signed [TG_CRD_W-1:0] pos;
        logic                       below;
        logic                       beyond;

        assign pos    = $signed({origin[d][TG_ORG_W-1], origin[d]})
                      + $signed({{(TG_CRD_W-TG_BOX_W){1'b0}}, offs[d]});
        assign below  = pos[TG_CRD_W-1];
        assign beyond = pos >= $signed({1'b0, extent[d]});
        assign coord[d] = dim_on[d] ? pos : '0;
        assign hit[d]   = dim_on[d] && (below || beyond);
    end

    assign oob = |hit;
endmodule

// File: rtl/tg_addr_sum.sv
module tg_addr_sum
    import tile_gen_pkg::*;
(
    input  logic [TG_ADDR_W-1:0]              base,
    input  logic [1:0]                        esz_log2,
    input  logic [TG_DIMS-1:1]                dim_on,
    input  logic [TG_DIMS-1:1][TG_STR_W-1:0]  stride,
    input  logic [TG_DIMS-1:0][TG_CRD_W-1:0]  coord,
    input  logic                              oob,
    output logic [TG_ADDR_W-1:0]              addr
);
    logic [TG_ADDR_W-1:0] acc;

    always_comb begin
        // dimension 0 is packed: offset is index scaled by element size
        acc = base + (tg_sext(coord[0]) << esz_log2);
        for (int d = 1; d < TG_DIMS; d++) begin
            if (dim_on[d]) begin
                acc = acc + tg_sext(coord[d])
                          * {{(TG_ADDR_W-TG_STR_W){1'b0}}, stride[d]};
            end
        end
        addr = oob ? '0 : acc;
    end
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
    import tile_gen_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start,
    input  logic [TG_DIMS-1:0][TG_ORG_W-1:0]  origin,
    input  logic [TG_ADDR_W-1:0]              base_addr,
    input  logic [TG_RANK_W-1:0]              rank,
    input  logic [1:0]                        elem_log2,
    input  logic                              nan_fill,
    input  logic [TG_DIMS-1:0][TG_EXT_W-1:0]  extent,
    input  logic [TG_DIMS-1:1][TG_STR_W-1:0]  stride,
    input  logic [TG_DIMS-1:0][TG_BOX_W-1:0]  step,
    input  logic [TG_DIMS-1:0][TG_BOX_W-1:0]  box,
    output logic                              req_valid,
    input  logic                              req_ready,
    output logic [TG_ADDR_W-1:0]              req_addr,
    output logic [TG_DIMS-1:0][TG_CRD_W-1:0]  req_coord,
    output logic                              req_oob,
    output logic [TG_FILL_W-1:0]              req_fill,
    output logic                              done
);
    tg_state_e                         state_q;
    tg_job_t                           job_q;
    logic                              done_q;
    logic                              accept;
    logic                              fire;
    logic                              walk_end;
    logic [TG_DIMS:0]                  carry;
    logic [TG_DIMS-1:0]                dim_last;
    logic [TG_DIMS-1:0]                dim_on;
    logic [TG_DIMS-1:0][TG_BOX_W-1:0]  offs;

    assign accept   = start && (state_q == TG_IDLE);
    assign fire     = req_valid && req_ready;
    assign carry[0] = 1'b1;
    assign walk_end = carry[TG_DIMS];

    // one odometer digit per dimension, dimension 0 least significant
    for (genvar d = 0; d < TG_DIMS; d++) begin : g_step
        assign dim_on[d] = (TG_RANK_W'(d) < job_q.rank);

        tg_dim_stepper u_stepper (
            .clk      (clk),
            .rst      (rst),
            .load     (accept),
            .advance  (fire),
            .carry_in (carry[d]),
            .active   (dim_on[d]),
            .step     (job_q.step[d]),
            .box      (job_q.box[d]),
            .off      (offs[d]),
            .last     (dim_last[d])
        );

        assign carry[d+1] = carry[d] & dim_last[d];
    end

    tg_bounds u_bounds (
        .dim_on (dim_on),
        .origin (job_q.origin),
        .extent (job_q.extent),
        .offs   (offs),
        .coord  (req_coord),
        .oob    (req_oob)
    );

    tg_addr_sum u_addr (
        .base     (job_q.base),
        .esz_log2 (job_q.esz_log2),
        .dim_on   (dim_on[TG_DIMS-1:1]),
        .stride   (job_q.stride),
        .coord    (req_coord),
        .oob      (req_oob),
        .addr     (req_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TG_IDLE;
            job_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= fire && walk_end;
            if (accept) begin
                state_q        <= TG_WALK;
                job_q.base     <= base_addr;
                job_q.rank     <= rank;
                job_q.esz_log2 <= elem_log2;
                job_q.nan_fill <= nan_fill;
                job_q.origin   <= origin;
                job_q.extent   <= extent;
                job_q.stride   <= stride;
                job_q.step     <= step;
                job_q.box      <= box;
            end else if (fire && walk_end) begin
                state_q <= TG_IDLE;
            end
        end
    end

    assign req_valid = (state_q == TG_WALK);
    assign req_fill  = (req_oob && job_q.nan_fill) ? tg_nan(job_q.esz_log2) : '0;
    assign done      = done_q;
endmodule

// File: rtl/tile_addr_gen_chk.sv
module tile_addr_gen_chk
    import tile_gen_pkg::*;
(
    input logic                              clk,
    input logic                              rst,
    input logic                              req_valid,
    input logic                              req_ready,
    input logic [TG_ADDR_W-1:0]              req_addr,
    input logic [TG_DIMS-1:0][TG_CRD_W-1:0]  req_coord,
    input logic                              req_oob,
    input logic [TG_FILL_W-1:0]              req_fill,
    input logic                              done,
    input logic [TG_EXT_W-1:0]               ext0
);
    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)
            && $stable(req_coord) && $stable(req_oob) && $stable(req_fill));

    // R9
    done_after_fire_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(req_valid && req_ready));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_valid);

    // R5
    inbound_dim0_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_oob |-> !req_coord[0][TG_CRD_W-1]
            && (req_coord[0] < {1'b0, ext0}));

    // R2
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> done || !$stable(req_coord));
endmodule

bind tile_addr_gen tile_addr_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_coord (req_coord),
    .req_oob   (req_oob),
    .req_fill  (req_fill),
    .done      (done),
    .ext0      (job_q.extent[0])
);

// File: tb/tile_addr_gen_bench.sv
`timescale 1ns/1ps
module tile_addr_gen_bench;
    import tile_gen_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                              rst;
    logic                              start;
    logic [TG_DIMS-1:0][TG_ORG_W-1:0]  origin;
    logic [TG_ADDR_W-1:0]              base_addr;
    logic [TG_RANK_W-1:0]              rank;
    logic [1:0]                        elem_log2;
    logic                              nan_fill;
    logic [TG_DIMS-1:0][TG_EXT_W-1:0]  extent;
    logic [TG_DIMS-1:1][TG_STR_W-1:0]  stride;
    logic [TG_DIMS-1:0][TG_BOX_W-1:0]  step;
    logic [TG_DIMS-1:0][TG_BOX_W-1:0]  box;
    logic                              req_valid;
    logic                              req_ready;
    logic [TG_ADDR_W-1:0]              req_addr;
    logic [TG_DIMS-1:0][TG_CRD_W-1:0]  req_coord;
    logic                              req_oob;
    logic [TG_FILL_W-1:0]              req_fill;
    logic                              done;

    tile_addr_gen u_tile_addr_gen (
        .clk(clk), .rst(rst), .start(start), .origin(origin),
        .base_addr(base_addr), .rank(rank), .elem_log2(elem_log2),
        .nan_fill(nan_fill), .extent(extent), .stride(stride),
        .step(step), .box(box), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_coord(req_coord),
        .req_oob(req_oob), .req_fill(req_fill), .done(done)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // reference job
    longint m_base;
    int     m_rank, m_esz;
    bit     m_nan;
    int     m_org[5], m_ext[5], m_step[5], m_box[5];
    longint m_str[5];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [63:0] nan_of(input int esz);
        case (esz)
            0:       return 64'h7F;
            1:       return 64'h7E00;
            2:       return 64'h7FC0_0000;
            default: return 64'h7FF8_0000_0000_0000;
        endcase
    endfunction

    task automatic note(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic drive_job();
        base_addr = m_base[47:0];
        rank      = 3'(m_rank);
        elem_log2 = 2'(m_esz);
        nan_fill  = m_nan;
        for (int d = 0; d < 5; d++) begin
            origin[d] = 16'(m_org[d]);
            extent[d] = 16'(m_ext[d]);
            step[d]   = 8'(m_step[d]);
            box[d]    = 8'(m_box[d]);
        end
        for (int d = 1; d < 5; d++) stride[d] = 32'(m_str[d]);
    endtask

    task automatic scramble();
        base_addr = ~base_addr;
        rank      = 3'd1;
        elem_log2 = ~elem_log2;
        nan_fill  = ~nan_fill;
        for (int d = 0; d < 5; d++) begin
            origin[d] = origin[d] + 16'd7;
            extent[d] = 16'd1;
            step[d]   = 8'd3;
            box[d]    = 8'd9;
        end
        for (int d = 1; d < 5; d++) stride[d] = stride[d] + 32'd64;
    endtask

    task automatic set_plain();
        m_base = 64'h0000_1000_0000; m_rank = 1; m_esz = 0; m_nan = 1'b0;
        for (int d = 0; d < 5; d++) begin
            m_org[d] = 0; m_ext[d] = 1; m_step[d] = 1; m_box[d] = 1; m_str[d] = 0;
        end
    endtask

    // Launch the job and follow every expected request in order.
    task automatic walk(input string tag, input int rmode, input bit disturb);
        int cnt[5];
        int k;
        k = 0;
        drive_job();
        @(negedge clk) start = 1'b1;
        req_ready = 1'b0;
        @(negedge clk) start = 1'b0;
        for (int d = 0; d < 5; d++)
            cnt[d] = (d < m_rank) ? (m_box[d] + m_step[d] - 1) / m_step[d] : 1;
        for (int i4 = 0; i4 < cnt[4]; i4++)
        for (int i3 = 0; i3 < cnt[3]; i3++)
        for (int i2 = 0; i2 < cnt[2]; i2++)
        for (int i1 = 0; i1 < cnt[1]; i1++)
        for (int i0 = 0; i0 < cnt[0]; i0++) begin
            int ix[5];
            longint c[5];
            bit eo;
            logic [47:0] ea;
            logic [63:0] ef;
            int tries;
            bit got;
            bit ok;
            ix[0] = i0; ix[1] = i1; ix[2] = i2; ix[3] = i3; ix[4] = i4;
            eo = 1'b0;
            for (int d = 0; d < 5; d++) begin
                if (d < m_rank) begin
                    c[d] = m_org[d] + ix[d] * m_step[d];
                    if (c[d] < 0 || c[d] >= m_ext[d]) eo = 1'b1;
                end else c[d] = 0;
            end
            ea = 48'(m_base + (c[0] << m_esz));
            for (int d = 1; d < m_rank; d++) ea = ea + 48'(c[d] * m_str[d]);
            if (eo) ea = '0;
            ef = (eo && m_nan) ? nan_of(m_esz) : 64'h0;
            tries = 0;
            got = 1'b0;
            while (!got) begin
                start = disturb && (k == 2) && (tries == 0);
                if (start) scramble();
                req_ready = (rmode == 0) ? 1'b1 : ((k % 2 == 1) ? (tries >= 1) : 1'b1);
                #1;
                ok = req_valid && (req_addr == ea) && (req_oob == eo) && (req_fill == ef);
                for (int d = 0; d < 5; d++) ok = ok && (req_coord[d] == 17'(c[d]));
                note(ok, $sformatf("%s R8 elem %0d: valid=%b addr=%h/%h oob=%b/%b fill=%h/%h c0=%0d/%0d c1=%0d/%0d",
                     tag, k, req_valid, req_addr, ea, req_oob, eo, req_fill, ef,
                     $signed(req_coord[0]), c[0], $signed(req_coord[1]), c[1]));
                if (req_valid && req_ready) got = 1'b1;
                @(negedge clk);
                start = 1'b0;
                tries++;
                if (tries > 50 && !got) begin
                    note(1'b0, $sformatf("%s R2 elem %0d: accepted=0 expected=1", tag, k));
                    got = 1'b1;
                end
            end
            k++;
        end
        req_ready = 1'b0;
        #1;
        note(done && !req_valid, $sformatf("%s R9 pulse: done=%b/1 valid=%b/0", tag, done, req_valid));
        @(negedge clk); #1;
        note(!done && !req_valid, $sformatf("%s R9 after: done=%b/0 valid=%b/0", tag, done, req_valid));
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; req_ready = 1'b0;
        set_plain(); drive_job();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        note(!req_valid && !done, $sformatf("R7 reset: valid=%b/0 done=%b/0", req_valid, done));
        @(negedge clk);
    endtask

    task automatic t_line();
        set_plain();
        m_esz = 1; m_ext[0] = 20; m_box[0] = 8; m_org[0] = 3;
        walk("R2/R3/R4 line", 0, 1'b0);
    endtask

    task automatic t_plane_stall();
        set_plain();
        m_rank = 2; m_esz = 2; m_base = 64'h0000_2000_0040;
        m_ext[0] = 10; m_ext[1] = 6; m_str[1] = 256;
        m_box[0] = 6; m_box[1] = 3; m_step[0] = 2; m_org[0] = 1; m_org[1] = 2;
        walk("R2/R4/R8 plane", 1, 1'b0);
    endtask

    task automatic t_edges_zero();
        set_plain();
        m_rank = 2; m_esz = 1; m_nan = 1'b0;
        m_ext[0] = 5; m_ext[1] = 5; m_str[1] = 64;
        m_box[0] = 4; m_box[1] = 3; m_org[0] = -2; m_org[1] = 4;
        walk("R5/R6 zero edge", 1, 1'b0);
    endtask

    task automatic t_nan_widths();
        for (int e = 0; e < 4; e++) begin
            set_plain();
            m_esz = e; m_nan = 1'b1;
            m_ext[0] = 6; m_box[0] = 4; m_org[0] = 4;
            walk($sformatf("R6 nan esz%0d", e), 0, 1'b0);
        end
    endtask

    task automatic t_high_rank();
        set_plain();
        m_rank = 5; m_esz = 3; m_base = 64'h0000_0100_0000;
        for (int d = 0; d < 5; d++) begin m_box[d] = 2; m_ext[d] = 4; end
        m_str[1] = 64; m_str[2] = 512; m_str[3] = 4096; m_str[4] = 65536;
        m_org[4] = 3; m_step[3] = 2; m_box[3] = 3;
        walk("R2/R4/R5 rank5", 1, 1'b0);
        set_plain();
        m_rank = 3; m_esz = 0; m_str[1] = 32; m_str[2] = 1024;
        m_ext[0] = 8; m_ext[1] = 8; m_ext[2] = 8;
        m_box[0] = 3; m_box[1] = 2; m_box[2] = 2;
        m_box[3] = 4; m_box[4] = 5; m_org[3] = 9; m_org[4] = -3; m_ext[4] = 1;
        walk("R2/R3/R5 rank3 upper ignored", 0, 1'b0);
    endtask

    task automatic t_busy_start();
        set_plain();
        m_rank = 2; m_esz = 1; m_ext[0] = 4; m_ext[1] = 4; m_str[1] = 128;
        m_box[0] = 3; m_box[1] = 2;
        walk("R1 busy start", 0, 1'b1);
        repeat (3) begin
            #1;
            note(!req_valid, $sformatf("R1 no extra walk: valid=%b/0", req_valid));
            @(negedge clk);
        end
    endtask

    initial begin
        t_reset();
        t_line();
        t_plane_stall();
        t_edges_zero();
        t_nan_widths();
        t_high_rank();
        t_busy_start();
        t_line();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule